// File: doc/BRIEF.md
# Slow Idle Clock Divider

This block sits between the input clock and the core of a small processor and turns a single free-running clock into a set of clock enables. At full rate the core enable is high on every input cycle. When the sequencer issues an idle command that carries a divisor, the block enters a slowed state. In that state the core enable pulses once every 16, 32, 64 or 128 input cycles. The core keeps working normally in this state; it simply advances at the lower rate.

The serial-clock enable, the timer tick enable and the clock-output enable are all derived from the core enable. As a result, every derived rate scales by the same ratio without separate logic. An idle command without a divisor is a plain idle: it raises the idle-status flag but leaves the clock at full rate, and the sequencer holds execution. Any pending unmasked interrupt ends either kind of idle. Plain idle ends on the next cycle. Slowed idle ends only after the next core pulse at the end of a divided period, so the enable pattern is never cut short. The clock-output enable can be forced off by its own control bit in any mode.

All pins are plain control and status lines. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. Only enables are produced; the block contains no clock gating cells.

Top module: `slowidle_clkdiv`

## Requirements
- R1: After reset the block is at full rate: core_en is 1 on every cycle, idle_flag is 0 and clkout_en is 1.
- R2: An idle_req with idle_plain=0 enters slowed idle with divisor 16 << div_code (00=16, 01=32, 10=64, 11=128). The first core_en pulse comes N-1 cycles after the entry cycle, and pulses then repeat every N cycles, with core_en 0 in between.
- R3: An idle_req with idle_plain=1 enters plain idle: idle_flag is 1, core_en stays 1 on every cycle, and div_code is ignored.
- R4: sport_en is 1 on exactly one of every SPORT_BASE (default 4) core_en pulses, and only in a cycle where core_en is 1. This holds at full rate and in slowed idle.
- R5: timer_en is 1 on exactly one of every TIMER_BASE (default 2) core_en pulses, and only in a cycle where core_en is 1, in every mode.
- R6: clkout_en equals core_en while clkout_off is 0, and is 0 while clkout_off is 1, whatever the idle mode.
- R7: In slowed idle, an asserted irq_pending (or one seen earlier in the same idle) ends idle in the cycle after the next core_en pulse. From then on idle_flag is 0 and core_en is 1 on every cycle.
- R8: In plain idle, an asserted irq_pending returns the block to full run state on the next cycle (idle_flag 0).
- R9: An idle_req that arrives while the block is already idle is ignored. The mode and the divided period stay unchanged.
- R10: irq_pending while running (not idle) has no effect: idle_flag stays 0 and core_en stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idle_req | input | 1 | One-cycle idle command strobe |
| idle_plain | input | 1 | 1 = plain idle (no divisor), sampled with idle_req |
| div_code | input | 2 | Divisor code 00=16, 01=32, 10=64, 11=128, sampled with idle_req |
| irq_pending | input | 1 | An unmasked interrupt is pending |
| clkout_off | input | 1 | 1 forces the clock-output enable off |
| core_en | output | 1 | Core clock enable |
| sport_en | output | 1 | Serial clock tick enable |
| timer_en | output | 1 | Timer tick enable |
| clkout_en | output | 1 | Clock output enable |
| idle_flag | output | 1 | 1 while in plain or slowed idle |

## Verification
Slowed idle is tried with the smallest and largest divisor codes (16 and 128) and with a middle one (32). Checking the exact cycle of each core pulse separates the four codes and would catch a period that is off by one. The derived serial and timer enables are counted against core pulses both at full rate and in slowed idle; this shows whether they follow the same ratio or run from the raw clock. Wake-up is tested once with the interrupt raised mid-period, where it must wait for the period end, and once from plain idle, where it must take effect at once. A second idle command during idle and an interrupt while running show that neither input leaks into a state where it has no meaning.

// File: rtl/slowidle_pkg.sv
package slowidle_pkg;

  // Base divisor and counter width for the slowed rate.
  localparam int unsigned BASE_DIV = 16;
  localparam int unsigned CODE_W   = 2;
  localparam int unsigned MAX_DIV  = BASE_DIV << ((1 << CODE_W) - 1);
  localparam int unsigned CNT_W    = $clog2(MAX_DIV);

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_PLAIN = 2'd1,
    MODE_SLOW  = 2'd2
  } mode_e;

  // Terminal count (divisor - 1) for a divisor code.
  function automatic logic [CNT_W-1:0] term_of(input logic [CODE_W-1:0] code);
    logic [CNT_W:0] full;
    full = (CNT_W+1)'(BASE_DIV) << code;
    return CNT_W'(full - 1'b1);
  endfunction

endpackage

// File: rtl/slowidle_ctrl.sv
module slowidle_ctrl
  import slowidle_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idle_req,
  input  logic  idle_plain,
  input  logic  irq_pending,
  input  logic  period_end,
  output mode_e mode,
  output logic  slow_start
);

  mode_e mode_q, mode_d;
  logic  wake_q, wake_d;

  assign slow_start = (mode_q == MODE_RUN) && idle_req && !idle_plain;

  always_comb begin
    mode_d = mode_q;
    wake_d = wake_q;
    unique case (mode_q)
      MODE_RUN: begin
        wake_d = 1'b0;
        if (idle_req) mode_d = idle_plain ? MODE_PLAIN : MODE_SLOW;
      end
      MODE_PLAIN: begin
        if (irq_pending) mode_d = MODE_RUN;
      end
      MODE_SLOW: begin
        if (irq_pending) wake_d = 1'b1;
        if (period_end && (wake_q || irq_pending)) begin
          mode_d = MODE_RUN;
          wake_d = 1'b0;
        end
      end
      default: mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      wake_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      wake_q <= wake_d;
    end
  end

  assign mode = mode_q;

  // R8: plain idle leaves on the cycle after an interrupt
  a_r8_plain_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_PLAIN && irq_pending) |=> (mode_q == MODE_RUN));

  // R10: without an idle command the running state is kept
  a_r10_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_RUN && !idle_req) |=> (mode_q == MODE_RUN));

  // R7: slowed idle is left only at a period end
  a_r7_exit_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SLOW && !period_end) |=> (mode_q == MODE_SLOW));

endmodule

// File: rtl/slowidle_divcnt.sv
module slowidle_divcnt
  import slowidle_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              active,
  output logic              tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_q;

  assign tick = active && (cnt_q == term_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      term_q <= '1;
    end else if (start) begin
      cnt_q  <= '0;
      term_q <= term_of(code);
    end else if (active) begin
      cnt_q <= (cnt_q == term_q) ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: divided pulses are never adjacent (smallest divisor is 16)
  a_r2_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  // R9: the period length cannot change during a slowed idle
  a_r9_term_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(term_q));

endmodule

// File: rtl/slowidle_prescale.sv
module slowidle_prescale #(
  parameter int unsigned BASE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic pulse
);

  generate
    if (BASE <= 1) begin : g_pass
      assign pulse = step;
    end else begin : g_count
      localparam int unsigned PW = $clog2(BASE);
      localparam logic [PW-1:0] LAST = PW'(BASE - 1);
      logic [PW-1:0] cnt_q;

      assign pulse = step && (cnt_q == LAST);

      always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (step) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/slowidle_clkdiv.sv
module slowidle_clkdiv
  import slowidle_pkg::*;
#(
  parameter int unsigned SPORT_BASE = 4,
  parameter int unsigned TIMER_BASE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idle_req,
  input  logic        idle_plain,
  input  logic [1:0]  div_code,
  input  logic        irq_pending,
  input  logic        clkout_off,
  output logic        core_en,
  output logic        sport_en,
  output logic        timer_en,
  output logic        clkout_en,
  output logic        idle_flag
);

  mode_e mode;
  logic  slow_start;
  logic  slow_tick;
  logic  slow_active;

  assign slow_active = (mode == MODE_SLOW);

  slowidle_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .idle_req   (idle_req),
    .idle_plain (idle_plain),
    .irq_pending(irq_pending),
    .period_end (slow_tick),
    .mode       (mode),
    .slow_start (slow_start)
  );

  slowidle_divcnt u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (slow_start),
    .code  (div_code),
    .active(slow_active),
    .tick  (slow_tick)
  );

  assign core_en   = slow_active ? slow_tick : 1'b1;
  assign clkout_en = core_en && !clkout_off;
  assign idle_flag = (mode != MODE_RUN);

  slowidle_prescale #(.BASE(SPORT_BASE)) u_sport (
    .clk  (clk),
    .rst_n(rst_n),
    .step (core_en),
    .pulse(sport_en)
  );

  slowidle_prescale #(.BASE(TIMER_BASE)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .step (core_en),
    .pulse(timer_en)
  );

  // R1: outside slowed idle the core runs every cycle
  a_r1_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
    !slow_active |-> core_en);

  // R3: plain idle keeps the full rate
  a_r3_plain_full: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_PLAIN) |-> (core_en && idle_flag));

  // R4: serial tick only with a core pulse
  a_r4_sport_in_core: assert property (@(posedge clk) disable iff (!rst_n)
    sport_en |-> core_en);

  // R5: timer tick only with a core pulse
  a_r5_timer_in_core: assert property (@(posedge clk) disable iff (!rst_n)
    timer_en |-> core_en);

  // R6: forced-off clock output
  a_r6_clkout_off: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_off |-> !clkout_en);

endmodule

// File: tb/slowidle_clkdiv_tb.sv
module slowidle_clkdiv_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idle_req = 1'b0, idle_plain = 1'b0, irq_pending = 1'b0, clkout_off = 1'b0;
  logic [1:0] div_code = 2'b00;
  logic core_en, sport_en, timer_en, clkout_en, idle_flag;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  slowidle_clkdiv u_dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .idle_plain(idle_plain),
    .div_code(div_code), .irq_pending(irq_pending), .clkout_off(clkout_off),
    .core_en(core_en), .sport_en(sport_en), .timer_en(timer_en),
    .clkout_en(clkout_en), .idle_flag(idle_flag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Issue an idle command; returns at the first negedge inside the idle state.
  task automatic enter_idle(input bit plain, input logic [1:0] code);
    idle_req = 1'b1; idle_plain = plain; div_code = code;
    @(negedge clk);
    idle_req = 1'b0; idle_plain = 1'b0; div_code = 2'b00;
  endtask

  // Raise irq until idle ends; returns the number of negedges waited.
  task automatic wake_up(output int waited);
    irq_pending = 1'b1;
    waited = 0;
    while (idle_flag && waited < 400) begin
      @(negedge clk);
      waited++;
    end
    irq_pending = 1'b0;
  endtask

  task automatic t_reset;
    check(core_en == 1'b1 && idle_flag == 1'b0 && clkout_en == 1'b1, "R1 reset state",
          {core_en, idle_flag, clkout_en}, 3'b101);
  endtask

  // R2, R6, R7: slowed idle pulse positions and wake at period end
  task automatic t_slow(input logic [1:0] code);
    int n = 16 << code;
    int miss = 0, ck_miss = 0, flag_miss = 0, waited;
    enter_idle(1'b0, code);
    for (int i = 0; i < 2 * n; i++) begin
      if (core_en != ((i == n - 1) || (i == 2 * n - 1))) miss++;
      if (clkout_en != core_en) ck_miss++;
      if (!idle_flag) flag_miss++;
      @(negedge clk);
    end
    check(miss == 0, "R2 slowed pulse positions", miss, 0);
    check(ck_miss == 0, "R6 clkout follows core", ck_miss, 0);
    check(flag_miss == 0, "R2 idle_flag held", flag_miss, 0);
    // now at offset 2n (start of the third period); wake mid-period
    repeat (3) @(negedge clk);
    wake_up(waited);
    check(waited == n - 3, "R7 wake at period end", waited, n - 3);
    miss = 0;
    for (int i = 0; i < 5; i++) begin
      if (!core_en || idle_flag) miss++;
      @(negedge clk);
    end
    check(miss == 0, "R7 full rate after wake", miss, 0);
  endtask

  // R3, R8: plain idle
  task automatic t_plain;
    int miss = 0;
    enter_idle(1'b1, 2'b11);
    for (int i = 0; i < 20; i++) begin
      if (!core_en || !idle_flag) miss++;
      @(negedge clk);
    end
    check(miss == 0, "R3 plain idle at full rate", miss, 0);
    irq_pending = 1'b1;
    @(negedge clk);
    irq_pending = 1'b0;
    check(idle_flag == 1'b0, "R8 plain wake next cycle", idle_flag, 0);
  endtask

  // R9: second idle command during slowed idle
  task automatic t_ignore;
    int miss = 0, waited;
    enter_idle(1'b0, 2'b00);
    for (int i = 0; i < 48; i++) begin
      if (i == 5) begin idle_req = 1'b1; idle_plain = 1'b1; div_code = 2'b11; end
      if (i == 6) begin idle_req = 1'b0; idle_plain = 1'b0; div_code = 2'b00; end
      if (i == 20) begin idle_req = 1'b1; div_code = 2'b11; end
      if (i == 21) begin idle_req = 1'b0; div_code = 2'b00; end
      if (core_en != ((i % 16) == 15)) miss++;
      if (!idle_flag) miss++;
      @(negedge clk);
    end
    check(miss == 0, "R9 idle_req ignored in idle", miss, 0);
    wake_up(waited);
  endtask

  // R10: interrupt while running
  task automatic t_irq_run;
    int miss = 0;
    irq_pending = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (!core_en || idle_flag) miss++;
    end
    irq_pending = 1'b0;
    check(miss == 0, "R10 irq while running", miss, 0);
  endtask

  // R4, R5: derived enables follow the core pulses
  task automatic t_ratio(input int cycles, input string tag);
    int cs = 0, ct = 0, sp_miss = 0, tm_miss = 0, sp_seen = 0, tm_seen = 0;
    for (int i = 0; i < cycles; i++) begin
      if (core_en) begin cs++; ct++; end
      if (sport_en) begin
        if (!core_en) sp_miss++;
        if (sp_seen > 0 && cs != 4) sp_miss++;
        cs = 0; sp_seen++;
      end
      if (timer_en) begin
        if (!core_en) tm_miss++;
        if (tm_seen > 0 && ct != 2) tm_miss++;
        ct = 0; tm_seen++;
      end
      @(negedge clk);
    end
    check(sp_miss == 0 && sp_seen >= 2, {"R4 sport ratio ", tag}, sp_miss, 0);
    check(tm_miss == 0 && tm_seen >= 2, {"R5 timer ratio ", tag}, tm_miss, 0);
  endtask

  task automatic t_ratio_slow;
    int waited;
    enter_idle(1'b0, 2'b00);
    t_ratio(16 * 4 * 3 + 8, "slow");
    wake_up(waited);
  endtask

  // R6: clock output forced off in both modes
  task automatic t_clkout_off;
    int miss = 0, waited;
    clkout_off = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (clkout_en || !core_en) miss++;
    end
    enter_idle(1'b0, 2'b00);
    for (int i = 0; i < 40; i++) begin
      if (clkout_en) miss++;
      @(negedge clk);
    end
    wake_up(waited);
    clkout_off = 1'b0;
    @(negedge clk);
    check(miss == 0, "R6 clkout forced off", miss, 0);
    check(clkout_en == 1'b1, "R6 clkout back on", clkout_en, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ratio(40, "full");
    t_slow(2'b00);
    t_slow(2'b11);
    t_slow(2'b01);
    t_plain();
    t_ignore();
    t_irq_run();
    t_ratio_slow();
    t_clkout_off();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule